// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a single-cycle request/acknowledge host port to an external asynchronous static RAM. The RAM has 19 address bits, an 8-bit data bus, an active-low chip select, an active-low output enable and one combined read/write line. For each host request the controller drives the RAM control lines in the right order. It holds each phase for a whole number of clock cycles. Each count is derived at elaboration time from the RAM's nanosecond limits and the clock period parameter.

On a read, the controller selects the RAM, enables its outputs and waits for the access time. It then captures the bus on one clock edge and returns the byte with a one-cycle acknowledge. On a write, the read/write line falls first. The controller's own data driver stays off for a turnaround window, so the RAM has time to release the shared bus. The driver then presents the byte long enough to meet the setup and pulse-width limits. The write ends when read/write rises. The driver is released one cycle after that, together with chip select. Between accesses chip select is high and the RAM sits in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, chip select, output enable and read/write are all high (inactive), the data driver is off and ack is low.
- R2: A read holds chip select and output enable low and read/write high for RD_CYC cycles. RD_CYC is the largest of the address-access, output-enable-access and read-cycle counts, which is 8 at the defaults. The bus is captured on the edge that ends this window. rdata carries that byte while ack is high.
- R3: A write holds read/write low for TURN_CYC + WR_CYC cycles (8 at the defaults), with output enable kept high throughout. Chip select is low for one further cycle (9 in total).
- R4: The data driver switches on only after read/write has been low for TURN_CYC cycles (4 at the defaults). It is never on while output enable is low, and during a write it is on for WR_CYC + 1 cycles (5 at the defaults).
- R5: Read/write rises while the driver is still on and chip select is still low. The driver turns off on the edge where chip select rises.
- R6: At a 5 ns clock, every access meets the RAM limits. For reads: 40 ns from address and chip select, 25 ns from output enable, no contention during the RAM's 20 ns release. For writes: a 30 ns write pulse, 35 ns of chip select before the write ends, and 20 ns of data setup.
- R7: Each count is the ceiling of the limit divided by CLK_PERIOD_NS, with a minimum of one. WR_CYC is the largest of the data-setup count and of the pulse-width, chip-select-to-end and write-cycle counts each minus TURN_CYC. With a 12 ns period, a read takes 4 cycles and a write holds read/write low for 4 cycles with the driver on for 3.
- R8: Each accepted request produces exactly one single-cycle ack: 8 cycles after acceptance for a read, 9 for a write. A request raised while an access is in progress is ignored and does not touch the RAM.
- R9: Chip select is high in the ack cycle and stays high while no access is in progress.
- R10: Address and write data do not change while chip select stays low.
- R11: A byte written to any 19-bit address, including 0 and 0x7FFFF, reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request pulse, taken only when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write byte |
| ack | output | 1 | One-cycle completion strobe |
| rdata | output | DATA_W | Read byte, valid with ack |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_rw_n | output | 1 | RAM read/write, low = write |
| mem_dq_out | output | DATA_W | Byte driven onto the shared bus |
| mem_dq_oe | output | 1 | Enable for the bus driver |
| mem_dq_in | input | DATA_W | Shared bus as seen by the controller |

## Verification
The bench pairs the controller with a RAM model that timestamps every control edge. The model flags any write pulse, setup or access window shorter than the RAM limits, and any overlap between the two drivers. A design that enabled its driver without the turnaround window would collide with a RAM still releasing the bus after a read. That case is covered by issuing a write in the very cycle a read completes. A design that dropped the driver on the edge where read/write rises, or one off by a single wait cycle, would show up in the per-cycle counts of chip select, output enable, read/write and driver. A request arriving mid-write targets an address with a known byte. If that request were not ignored, the bench would see a second ack or a corrupted read-back. A second instance runs with a longer clock period and checks that the cycle counts scale by ceiling division.

// File: rtl/asram_ctrl_pkg.sv
`timescale 1ns/1ps
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WTURN = 3'd2,
    ST_WDATA = 3'd3,
    ST_WEND  = 3'd4
  } ctl_state_e;

  // Whole cycles covering a nanosecond limit, never fewer than one.
  function automatic int cycles_for(input int lim_ns, input int period_ns);
    int c;
    c = (lim_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_timer.sv
`timescale 1ns/1ps
module asram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_ctrl_fsm.sv
`timescale 1ns/1ps
module asram_ctrl_fsm
  import asram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 8,
  parameter int TURN_CYC = 4,
  parameter int WR_CYC   = 4,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic we,
  output logic accept,
  output logic capture,
  output logic ack,
  output logic ce_n,
  output logic oe_n,
  output logic rw_n,
  output logic dq_oe
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);

  ctl_state_e       st_q, st_d;
  logic             ce_n_q, ce_n_d, oe_n_q, oe_n_d, rw_n_q, rw_n_d;
  logic             drv_q, drv_d, ack_q, ack_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  asram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    ce_n_d   = ce_n_q;
    oe_n_d   = oe_n_q;
    rw_n_d   = rw_n_q;
    drv_d    = drv_q;
    ack_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          ce_n_d   = 1'b0;
          if (we) begin
            st_d    = ST_WTURN;
            tmr_val = TURN_LD;
            rw_n_d  = 1'b0;
            oe_n_d  = 1'b1;
          end else begin
            st_d    = ST_READ;
            tmr_val = RD_LD;
            rw_n_d  = 1'b1;
            oe_n_d  = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          capture = 1'b1;
          ack_d   = 1'b1;
          ce_n_d  = 1'b1;
          oe_n_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_WTURN: begin
        if (tmr_done) begin
          drv_d    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = WR_LD;
          st_d     = ST_WDATA;
        end
      end
      ST_WDATA: begin
        if (tmr_done) begin
          rw_n_d = 1'b1;
          st_d   = ST_WEND;
        end
      end
      ST_WEND: begin
        drv_d  = 1'b0;
        ce_n_d = 1'b1;
        ack_d  = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      rw_n_q <= 1'b1;
      drv_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ce_n_q <= ce_n_d;
      oe_n_q <= oe_n_d;
      rw_n_q <= rw_n_d;
      drv_q  <= drv_d;
      ack_q  <= ack_d;
    end
  end

  assign ce_n  = ce_n_q;
  assign oe_n  = oe_n_q;
  assign rw_n  = rw_n_q;
  assign dq_oe = drv_q;
  assign ack   = ack_q;

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n_q |-> oe_n_q); // R3
  AST_DRIVE_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> oe_n_q); // R4
  AST_DRIVE_AFTER_RW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> (!rw_n_q && $past(!rw_n_q))); // R4
  AST_RW_RISE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw_n_q) |-> (drv_q && !ce_n_q)); // R5
  AST_DRIVE_OFF_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_q) |-> (ce_n_q && rw_n_q)); // R5
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R8
  AST_ACK_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> ce_n_q); // R9

endmodule

// File: rtl/asram_ctrl_dpath.sv
`timescale 1ns/1ps
module asram_ctrl_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      addr_q <= addr;
      wd_q   <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (capture) rd_q <= dq_in;
  end

  assign mem_addr = addr_q;
  assign dq_out   = wd_q;
  assign rdata    = rd_q;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ACC_NS      = 40,
  parameter int T_OE_NS       = 25,
  parameter int T_RC_NS       = 40,
  parameter int T_WP_NS       = 30,
  parameter int T_CW_NS       = 35,
  parameter int T_DS_NS       = 20,
  parameter int T_WC_NS       = 40,
  parameter int T_TURN_NS     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_rw_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = max2(cycles_for(T_ACC_NS, CLK_PERIOD_NS),
                                 max2(cycles_for(T_OE_NS, CLK_PERIOD_NS),
                                      cycles_for(T_RC_NS, CLK_PERIOD_NS)));
  localparam int TURN_CYC = cycles_for(T_TURN_NS, CLK_PERIOD_NS);
  localparam int WR_CYC   = max2(1, max2(cycles_for(T_DS_NS, CLK_PERIOD_NS),
                                 max2(cycles_for(T_WP_NS, CLK_PERIOD_NS) - TURN_CYC,
                                 max2(cycles_for(T_CW_NS, CLK_PERIOD_NS) - TURN_CYC,
                                      cycles_for(T_WC_NS, CLK_PERIOD_NS) - TURN_CYC))));
  localparam int MAX_CYC  = max2(RD_CYC, max2(TURN_CYC, WR_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic rst_meta_n, rst_sync_n;
  logic accept, capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  asram_ctrl_fsm #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WR_CYC   (WR_CYC),
    .CNT_W    (CNT_W)
  ) i_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req),
    .we      (we),
    .accept  (accept),
    .capture (capture),
    .ack     (ack),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .rw_n    (mem_rw_n),
    .dq_oe   (mem_dq_oe)
  );

  asram_ctrl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .capture  (capture),
    .addr     (addr),
    .wdata    (wdata),
    .dq_in    (mem_dq_in),
    .mem_addr (mem_addr),
    .dq_out   (mem_dq_out),
    .rdata    (rdata)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R10
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_ce_n |-> !mem_dq_oe); // R9

endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_rw_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  wire  [7:0]  dq_bus;

  always #2.5 clk = ~clk;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_rw_n(mem_rw_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_bus)
  );

  // Second instance with a 12 ns period parameter, used for cycle counts only.
  logic        s_req, s_we, s_ack, s_ce_n, s_oe_n, s_rw_n, s_dq_oe;
  logic [7:0]  s_rdata, s_dq_out;
  logic [18:0] s_maddr;
  asram_ctrl #(.CLK_PERIOD_NS(12)) i_asram_ctrl_slow (
    .clk(clk), .rst_n(rst_n), .req(s_req), .we(s_we), .addr(19'h00042),
    .wdata(8'h99), .ack(s_ack), .rdata(s_rdata), .mem_addr(s_maddr),
    .mem_ce_n(s_ce_n), .mem_oe_n(s_oe_n), .mem_rw_n(s_rw_n),
    .mem_dq_out(s_dq_out), .mem_dq_oe(s_dq_oe), .mem_dq_in(8'h00)
  );

  // ---------------- RAM model with timing checks ----------------
  logic [7:0] ram [int];
  logic [7:0] ram_q = 8'h00;
  logic       ram_drv = 1'b0;
  logic       armed = 1'b0;
  realtime    t_ce_f = 0.0, t_oe_f = 0.0, t_rw_f = 0.0, t_addr = 0.0, t_dat = 0.0;
  realtime    t_rel = -100.0;
  int         tviol = 0;
  wire        rd_cond = (mem_ce_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_rw_n === 1'b1);

  assign dq_bus = (mem_dq_oe === 1'b1) ? mem_dq_out : (ram_drv ? ram_q : 8'hzz);

  always @(negedge mem_ce_n) t_ce_f = $realtime;
  always @(negedge mem_oe_n) t_oe_f = $realtime;
  always @(negedge mem_rw_n) t_rw_f = $realtime;
  always @(mem_addr)         t_addr = $realtime;
  always @(dq_bus)           t_dat  = $realtime;
  always @(negedge rd_cond)  t_rel  = $realtime;

  always @(posedge mem_oe_n) begin // end of a read
    if (armed) begin
      if ($realtime - t_ce_f < 40.0 || $realtime - t_oe_f < 25.0 ||
          $realtime - t_addr < 40.0) tviol++;
    end
  end

  always @(posedge mem_rw_n) begin // end of a write
    if (armed && mem_ce_n === 1'b0) begin
      if ($realtime - t_rw_f < 30.0 || $realtime - t_ce_f < 35.0 ||
          $realtime - t_dat < 20.0 || t_addr > t_rw_f) tviol++;
      ram[int'(mem_addr)] = dq_bus;
    end
  end

  initial begin
    #0.25;
    forever begin
      ram_drv = rd_cond || ($realtime - t_rel < 20.0);
      ram_q   = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
      if (ram_drv && mem_dq_oe === 1'b1) tviol++;
      #1;
    end
  end

  // ---------------- stability monitor ----------------
  int          moves = 0;
  logic        prev_ce_lo = 1'b0;
  logic [18:0] prev_addr;
  logic [7:0]  prev_dout;
  always @(negedge clk) begin
    if (armed && prev_ce_lo && mem_ce_n === 1'b0 &&
        (mem_addr !== prev_addr || (mem_dq_oe === 1'b1 && mem_dq_out !== prev_dout)))
      moves++;
    prev_ce_lo = (mem_ce_n === 1'b0);
    prev_addr  = mem_addr;
    prev_dout  = mem_dq_out;
  end

  // ---------------- bookkeeping ----------------
  int checks = 0, errors = 0;
  logic [7:0] shadow [int];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  int   c_ce, c_oe, c_rw, c_drv, c_drv_rwh, early, lat;
  logic ce_at_ack;
  logic [7:0] rd;

  // Raises req now (caller is at a negedge), then profiles the access.
  task automatic run_op(input bit w, input logic [18:0] a, input logic [7:0] d);
    int n, run;
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    c_ce = 0; c_oe = 0; c_rw = 0; c_drv = 0; c_drv_rwh = 0; early = 0; n = 0; run = 0;
    while (ack !== 1'b1 && n < 40) begin
      if (mem_ce_n === 1'b0) c_ce++;
      if (mem_oe_n === 1'b0) c_oe++;
      if (mem_rw_n === 1'b0) begin c_rw++; run++; end else run = 0;
      if (mem_dq_oe === 1'b1) begin
        c_drv++;
        if (mem_rw_n === 1'b1) c_drv_rwh++;
        else if (run <= 4) early++;
      end
      @(negedge clk);
      n++;
    end
    lat = n; rd = rdata; ce_at_ack = mem_ce_n;
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int v0;
    v0 = tviol;
    run_op(1'b1, a, d);
    chk(c_rw == 8, "R3 rw low cycles", c_rw, 8);
    chk(c_oe == 0, "R3 oe low during write", c_oe, 0);
    chk(c_ce == 9, "R3 ce low cycles on write", c_ce, 9);
    chk(c_drv == 5 && early == 0, "R4 driver window", c_drv * 16 + early, 5 * 16);
    chk(c_drv_rwh == 1, "R5 driver after rw rise", c_drv_rwh, 1);
    chk(lat == 9, "R8 write ack latency", lat, 9);
    chk(ce_at_ack === 1'b1, "R9 ce high at ack", ce_at_ack, 1);
    chk(tviol == v0, "R6 ram limits on write", tviol - v0, 0);
    shadow[int'(a)] = d;
  endtask

  task automatic t_read(input logic [18:0] a);
    int v0;
    logic [7:0] e;
    v0 = tviol;
    e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    run_op(1'b0, a, 8'h00);
    chk(c_ce == 8 && c_oe == 8, "R2 ce/oe low cycles", c_ce * 16 + c_oe, 8 * 16 + 8);
    chk(c_rw == 0 && c_drv == 0, "R2 rw high no drive", c_rw + c_drv, 0);
    chk(lat == 8, "R8 read ack latency", lat, 8);
    chk(rd === e, "R11 read data", rd, e);
    chk(ce_at_ack === 1'b1, "R9 ce high at ack", ce_at_ack, 1);
    chk(tviol == v0, "R6 ram limits on read", tviol - v0, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    s_req = 1'b0; s_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && mem_rw_n === 1'b1,
        "R1 controls idle in reset", {mem_ce_n, mem_oe_n, mem_rw_n}, 7);
    chk(mem_dq_oe === 1'b0 && ack === 1'b0, "R1 driver and ack off",
        {mem_dq_oe, ack}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1'b1;
    chk(mem_ce_n === 1'b1 && mem_dq_oe === 1'b0, "R1 idle after reset",
        {mem_ce_n, mem_dq_oe}, 2);
  endtask

  task automatic t_patterns;
    t_write(19'h00000, 8'hA5);
    t_write(19'h7FFFF, 8'h5A);
    t_write(19'h12345, 8'hFF);
    t_write(19'h55555, 8'h00);
    t_read(19'h00000);
    t_read(19'h7FFFF);
    t_read(19'h12345);
    t_read(19'h55555);
  endtask

  // Read finishing, write issued in the ack cycle: bus turnaround.
  task automatic t_turnaround;
    t_read(19'h7FFFF);
    t_write(19'h0ABCD, 8'h3E);
    t_read(19'h0ABCD);
    @(negedge clk);
    chk(ack === 1'b0, "R8 ack single cycle", ack, 0);
    chk(mem_ce_n === 1'b1, "R9 ce high when idle", mem_ce_n, 1);
  endtask

  task automatic t_busy;
    int acks;
    t_write(19'h00200, 8'h11);
    req = 1'b1; we = 1'b1; addr = 19'h00100; wdata = 8'h3C;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 19'h00200; wdata = 8'h77;
    @(negedge clk); req = 1'b0;
    acks = 0;
    for (int i = 0; i < 20; i++) begin
      if (ack === 1'b1) acks++;
      @(negedge clk);
    end
    shadow[32'h100] = 8'h3C;
    chk(acks == 1, "R8 one ack while busy request dropped", acks, 1);
    chk(mem_ce_n === 1'b1, "R9 ce high after drop", mem_ce_n, 1);
    t_read(19'h00200);
    t_read(19'h00100);
  endtask

  task automatic t_slow;
    int ce, rw, dr, n;
    @(negedge clk);
    s_req = 1'b1; s_we = 1'b0;
    @(negedge clk); s_req = 1'b0;
    ce = 0; n = 0;
    while (s_ack !== 1'b1 && n < 40) begin
      if (s_ce_n === 1'b0) ce++;
      @(negedge clk); n++;
    end
    chk(ce == 4, "R7 scaled read cycles", ce, 4);
    s_req = 1'b1; s_we = 1'b1;
    @(negedge clk); s_req = 1'b0;
    rw = 0; dr = 0; n = 0;
    while (s_ack !== 1'b1 && n < 40) begin
      if (s_rw_n === 1'b0) rw++;
      if (s_dq_oe === 1'b1) dr++;
      @(negedge clk); n++;
    end
    chk(rw == 4 && dr == 3, "R7 scaled write cycles", rw * 16 + dr, 4 * 16 + 3);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset;
    t_patterns;
    t_turnaround;
    t_busy;
    t_slow;
    chk(moves == 0, "R10 address/data held while selected", moves, 0);
    chk(tviol == 0, "R6 no ram violations overall", tviol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule